// File: doc/BRIEF.md
# Serial configuration-memory ID loader

This block runs once after system reset and fetches the hub's identity settings from an external three-wire serial EEPROM organised as 16-bit words. It generates the serial clock from the system clock and drives the shared data line while it sends the read command. It then releases the line and shifts in the data that the memory returns. Once the read is complete, both pins are released and left to their external pulldowns, so that another master can use the same memory.

The loader sends a 9-bit command: a start bit of 1, the read opcode 1 then 0, and word address zero, all MSB first. The memory answers with one dummy bit and then three consecutive words. Word 0 carries the ganged power-switching flag in bit 14. Word 1 is the vendor ID and word 2 is the product ID, each with its high byte in bits 15..8. If the memory is not fitted, the external-memory enable input is held high. The pins are then left alone, the default IDs are presented at once, and the ganged mode follows a strap pin. A dummy bit that reads back as 1 marks a failed read: an error flag is raised and the default IDs are kept.

Top module: `cfg_rom_loader`

## Requirements
- R1: With `xmem_en_n` low at the first clock after reset, exactly one access takes place. `done_o` rises 1 + 58*DIV clock cycles after reset is released and stays high until the next reset.
- R2: During the access, `sclk_oe_o` is high and `sclk_o` repeats a period of DIV system cycles: low for the first DIV/2 and high for the second DIV/2, with the first period starting at the first cycle after reset. `sclk_o` is 0 whenever `sclk_oe_o` is low.
- R3: During serial periods 0..8, `sdata_oe_o` is high and `sdata_o` carries the bits 1,1,0,0,0,0,0,0,0 in that order, one bit per period. `sdata_o` does not change while `sclk_o` is high.
- R4: From serial period 9 onward, `sdata_oe_o` is low. `sdata_i` is sampled in the last system cycle of each high phase, which is the falling edge of the serial clock.
- R5: The bit sampled in period 9 is the dummy bit. The 48 bits sampled in periods 10..57 fill word 0, then word 1, then word 2, each MSB first.
- R6: After `done_o`, `vid_o` equals word 1, `pid_o` equals word 2 and `ganged_o` equals bit 14 of word 0.
- R7: If the dummy bit is sampled as 1, `err_o` goes high together with `done_o`, `vid_o`/`pid_o` keep their defaults and `ganged_o` is 0. Otherwise `err_o` stays 0.
- R8: Once `done_o` is high, `sclk_oe_o`, `sdata_oe_o`, `sclk_o` and `sdata_o` are all 0.
- R9: With `xmem_en_n` high at the first clock after reset, no pin is ever enabled and `done_o` rises at that first clock. `vid_o`/`pid_o` show the defaults and `ganged_o` follows `gang_pin_i` combinationally.
- R10: Before `done_o`, `vid_o`/`pid_o` show DEF_VID/DEF_PID and `ganged_o` is 0. After `done_o`, `vid_o` and `pid_o` hold steady whatever `sdata_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| xmem_en_n | input | 1 | External memory present, active low; sampled once after reset |
| gang_pin_i | input | 1 | Strap value for ganged mode when no memory is fitted |
| sdata_i | input | 1 | Serial data returned by the memory |
| sclk_o | output | 1 | Serial clock |
| sclk_oe_o | output | 1 | Serial clock output enable |
| sdata_o | output | 1 | Serial data driven to the memory |
| sdata_oe_o | output | 1 | Serial data output enable |
| vid_o | output | 16 | Vendor ID |
| pid_o | output | 16 | Product ID |
| ganged_o | output | 1 | Ganged power-switching mode |
| done_o | output | 1 | Load finished |
| err_o | output | 1 | Dummy bit read back wrong; defaults in use |

## Verification
Pin outputs depend only on the number of clocks since reset release. After the t-th rising edge, `sclk_o` and the enables reflect serial period (t-1)/DIV and phase (t-1)%DIV. The bench model computes each output from t alone and compares it half a cycle after every edge. The memory model in the bench sets a new data bit half a system cycle after each rising serial clock it observes, well ahead of the DUT's sample point at the end of the high phase. The ID outputs are due at edge 58*DIV+1 with memory, or at edge 1 without it, and they are compared against defaults on every cycle before that point and against the words afterwards.

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader #(
  parameter int          DIV      = 64,
  parameter int          ADDR_W   = 6,
  parameter int          WORD_W   = 16,
  parameter int          GANG_BIT = 14,
  parameter logic [15:0] DEF_VID  = 16'hF0C1,
  parameter logic [15:0] DEF_PID  = 16'h7A00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xmem_en_n,
  input  logic        gang_pin_i,
  input  logic        sdata_i,
  output logic        sclk_o,
  output logic        sclk_oe_o,
  output logic        sdata_o,
  output logic        sdata_oe_o,
  output logic [15:0] vid_o,
  output logic [15:0] pid_o,
  output logic        ganged_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int HALF   = DIV / 2;
  localparam int CMD_W  = 3 + ADDR_W;
  localparam int DATA_W = 3 * WORD_W;
  localparam int NBITS  = CMD_W + 1 + DATA_W;
  localparam int CW     = $clog2(DIV);
  localparam int BW     = $clog2(NBITS + 1);
  localparam int GPOS   = CMD_W + 1 + (WORD_W - 1 - GANG_BIT);
  localparam logic [CMD_W-1:0] CMD = {3'b110, {ADDR_W{1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t                 st;
  logic [CW-1:0]       cnt;
  logic [BW-1:0]       bitn;
  logic [2*WORD_W-2:0] shreg;
  logic                bad, skip, gang_cap, gang_r;
  logic [15:0]         vid_r, pid_r;
  logic [2*WORD_W-1:0] last;
  logic                run, tick, drv;

  assign run  = (st == S_RUN);
  assign tick = run && (cnt == CW'(DIV - 1));
  assign drv  = run && (bitn < BW'(CMD_W));
  assign last = {shreg, sdata_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      bad      <= 1'b0;
      skip     <= 1'b0;
      gang_cap <= 1'b0;
      gang_r   <= 1'b0;
      vid_r    <= DEF_VID;
      pid_r    <= DEF_PID;
    end else begin
      case (st)
        S_IDLE: begin
          cnt  <= '0;
          bitn <= '0;
          if (xmem_en_n) begin
            skip <= 1'b1;
            st   <= S_DONE;
          end else begin
            st <= S_RUN;
          end
        end
        S_RUN: begin
          if (tick) begin
            cnt <= '0;
            if (bitn == BW'(CMD_W))
              bad <= sdata_i;
            if (bitn > BW'(CMD_W))
              shreg <= {shreg[2*WORD_W-3:0], sdata_i};
            if (bitn == BW'(GPOS))
              gang_cap <= sdata_i;
            if (bitn == BW'(NBITS - 1)) begin
              st <= S_DONE;
              if (!bad) begin
                vid_r  <= last[2*WORD_W-1:WORD_W];
                pid_r  <= last[WORD_W-1:0];
                gang_r <= gang_cap;
              end
            end else begin
              bitn <= bitn + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sclk_oe_o  = run;
  assign sclk_o     = run && (cnt >= CW'(HALF));
  assign sdata_oe_o = drv;
  assign sdata_o    = drv && CMD[CMD_W - 1 - int'(bitn)];
  assign done_o     = (st == S_DONE);
  assign err_o      = done_o && bad;
  assign vid_o      = vid_r;
  assign pid_o      = pid_r;
  assign ganged_o   = (done_o && skip) ? gang_pin_i : gang_r;
endmodule

// File: rtl/cfg_rom_loader_chk.sv
module cfg_rom_loader_chk #(
  parameter logic [15:0] DEF_VID = 16'hF0C1,
  parameter logic [15:0] DEF_PID = 16'h7A00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk_o,
  input logic        sclk_oe_o,
  input logic        sdata_o,
  input logic        sdata_oe_o,
  input logic [15:0] vid_o,
  input logic [15:0] pid_o,
  input logic        ganged_o,
  input logic        done_o,
  input logic        err_o
);
  // R2
  sclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_oe_o |-> !sclk_o);
  // R4
  data_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe_o |-> sclk_oe_o);
  // R3
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe_o && $past(sdata_oe_o) && sclk_o) |-> $stable(sdata_o));
  // R1
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!sclk_oe_o && !sdata_oe_o && !sclk_o && !sdata_o));
  // R7
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (done_o && vid_o == DEF_VID && pid_o == DEF_PID));
  // R10
  id_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (vid_o == DEF_VID && pid_o == DEF_PID && !ganged_o));
  // R10
  id_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> ($stable(vid_o) && $stable(pid_o)));
endmodule

bind cfg_rom_loader cfg_rom_loader_chk #(.DEF_VID(DEF_VID), .DEF_PID(DEF_PID)) chk_i (
  .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
  .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .vid_o(vid_o), .pid_o(pid_o),
  .ganged_o(ganged_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/cfg_rom_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_rom_loader_tb_top;
  localparam int          DIV   = 64;
  localparam int          NB    = 58;
  localparam logic [15:0] DVID  = 16'hF0C1;
  localparam logic [15:0] DPID  = 16'h7A00;
  localparam logic [8:0]  CMDB  = 9'b110_000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xmem_en_n = 1'b0, gang_pin_i = 1'b0, sdata_i = 1'b0;
  logic sclk_o, sclk_oe_o, sdata_o, sdata_oe_o, ganged_o, done_o, err_o;
  logic [15:0] vid_o, pid_o;

  cfg_rom_loader dut_i (
    .clk(clk), .rst_n(rst_n), .xmem_en_n(xmem_en_n), .gang_pin_i(gang_pin_i),
    .sdata_i(sdata_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .sdata_o(sdata_o),
    .sdata_oe_o(sdata_oe_o), .vid_o(vid_o), .pid_o(pid_o), .ganged_o(ganged_o),
    .done_o(done_o), .err_o(err_o)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  int t = 0, rises = 0;
  logic prev_sclk = 1'b0;
  logic [15:0] w0, w1, w2;
  logic bad_dummy = 1'b0;
  logic [47:0] stream;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0d", req, act, exp, t);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      t = 0; rises = 0; prev_sclk = 1'b0;
      chk("R1 reset done", {31'b0, done_o}, 0);
      chk("R2 reset sclk_oe", {31'b0, sclk_oe_o}, 0);
      chk("R10 reset vid", {16'b0, vid_o}, {16'b0, DVID});
    end else begin
      int p, b, c;
      logic run, dn, e_sclk, e_doe, e_d, e_err, e_g;
      logic [15:0] e_vid, e_pid;
      t = t + 1;
      p = t - 1; b = p / DIV; c = p % DIV;
      run = !xmem_en_n && t <= NB * DIV;
      dn  = xmem_en_n ? 1'b1 : (t >= NB * DIV + 1);
      e_sclk = run && c >= DIV / 2;
      e_doe  = run && b < 9;
      e_d    = e_doe ? CMDB[8 - b] : 1'b0;
      e_err  = dn && !xmem_en_n && bad_dummy;
      e_vid  = (dn && !xmem_en_n && !bad_dummy) ? w1 : DVID;
      e_pid  = (dn && !xmem_en_n && !bad_dummy) ? w2 : DPID;
      e_g    = !dn ? 1'b0 : (xmem_en_n ? gang_pin_i : (!bad_dummy && w0[14]));
      chk("R2 sclk", {31'b0, sclk_o}, {31'b0, e_sclk});
      chk("R2 sclk_oe", {31'b0, sclk_oe_o}, {31'b0, run});
      chk("R4 sdata_oe", {31'b0, sdata_oe_o}, {31'b0, e_doe});
      chk("R3 sdata_o", {31'b0, sdata_o}, {31'b0, e_d});
      chk(xmem_en_n ? "R9 done" : "R1 done", {31'b0, done_o}, {31'b0, dn});
      chk("R7 err", {31'b0, err_o}, {31'b0, e_err});
      chk(dn ? "R6 vid" : "R10 vid", {16'b0, vid_o}, {16'b0, e_vid});
      chk(dn ? "R6 pid" : "R10 pid", {16'b0, pid_o}, {16'b0, e_pid});
      chk(xmem_en_n ? "R9 ganged" : "R6 ganged", {31'b0, ganged_o}, {31'b0, e_g});
      if (sclk_o && !prev_sclk) begin
        if (rises >= 9) begin
          int idx;
          idx = rises - 9;
          if (idx == 0) sdata_i = bad_dummy;
          else if (idx <= 48) sdata_i = stream[48 - idx];
          else sdata_i = 1'b0;
        end
        rises++;
      end
      if (done_o) sdata_i = 1'($urandom);
      prev_sclk = sclk_o;
    end
  end

  task automatic do_run(input logic dis, input logic [15:0] a, input logic [15:0] bw,
                        input logic [15:0] cw, input logic bad, input int ncyc);
    @(negedge clk); #1;
    rst_n = 1'b0;
    xmem_en_n = dis; w0 = a; w1 = bw; w2 = cw; bad_dummy = bad;
    stream = {a, bw, cw}; sdata_i = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (ncyc) begin
      @(negedge clk); #1;
      gang_pin_i = 1'($urandom);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R5 R6: ganged set, distinct words
    do_run(1'b0, 16'h4000, 16'h1A2B, 16'h3C4D, 1'b0, NB * DIV + 40);
    chk("R5 word order vid", {16'b0, vid_o}, 32'h1A2B);
    chk("R5 word order pid", {16'b0, pid_o}, 32'h3C4D);
    chk("R8 lines released", {30'b0, sclk_oe_o, sdata_oe_o}, 0);
    // R6: ganged clear, extreme patterns
    do_run(1'b0, 16'h0000, 16'hFFFF, 16'h0001, 1'b0, NB * DIV + 40);
    chk("R6 ganged clear", {31'b0, ganged_o}, 0);
    // R7: bad dummy bit
    do_run(1'b0, 16'h4000, 16'h5555, 16'hAAAA, 1'b1, NB * DIV + 40);
    chk("R7 error flag", {31'b0, err_o}, 1);
    chk("R7 defaults kept", {16'b0, vid_o}, {16'b0, DVID});
    // R9: no memory fitted
    do_run(1'b1, 16'h4000, 16'h1111, 16'h2222, 1'b0, 200);
    chk("R9 no clock", {31'b0, sclk_oe_o}, 0);
    // R10: outputs hold while data line toggles after the load
    do_run(1'b0, 16'h4000, 16'hBEEF, 16'h0A0A, 1'b0, NB * DIV + 300);
    chk("R10 held vid", {16'b0, vid_o}, 32'hBEEF);
    chk("R10 held pid", {16'b0, pid_o}, 32'h0A0A);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule